// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a time-of-day and calendar core that sits behind eight byte registers at the top of an 8K x 8 byte-wide memory window. Register index 0 maps to byte 0x1FF8 and index 7 maps to byte 0x1FFF. A one-cycle strobe at 1 Hz advances a set of live BCD counters. These counters hold seconds, minutes, hours, weekday, date, month, year and a century flag.

Software never touches the live counters directly. It reads and writes a bank of shadow copies. A control byte gives software two halts. The first freezes the shadows so that a read is coherent while time keeps running. The second freezes the shadows so that new values can be loaded; clearing it commits those values to the counters in one step.

The block also holds:
- an oscillator stop bit, which halts counting;
- a century-toggle enable;
- a frequency-test storage bit;
- a battery-low flag, which samples an input pin at each midnight rollover.

The register port is synchronous and completes in a single cycle. A write takes effect at the clock edge. A read is combinational from the index. No stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the registers read as follows: control 0x00, seconds 0x80 (stop bit set, 00 s), minutes 0x00, hours 0x00, day 0x01 (weekday 1, century bit 0, century-enable 0, frequency-test 0), date 0x01, month 0x01, year 0x00, battery-low flag 0.
- R2: The registers are indexed 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. rdata follows addr in the same cycle. On a tick with neither halt bit set, every shadow takes the new counter value at the same edge.
- R3: Control bit 6 (read halt) freezes all shadows while the live counters keep counting. Once the bit is cleared, the next tick shows the time including every tick that was missed.
- R4: Control bit 7 (write halt) freezes the shadows against refresh while time registers are written. A control write that clears the bit while it is set copies all time shadows, including the century bit, into the counters.
- R5: Seconds bit 7 is the stop bit. It can be written at any time, and while it is 1 the counters do not advance on ticks.
- R6: Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00 with a day carry. Weekday (day bits 2:0) counts 1 to 7 and then returns to 1.
- R7: Date runs from 01 to the length of the month: 31; 30 for months 04, 06, 09 and 11; and for month 02, 29 when the year is divisible by 4 and 28 otherwise. Month wraps from 12 to 01 with a year carry.
- R8: Year wraps from 99 to 00. At that rollover the century bit (day bit 4) toggles if century-enable (day bit 5) is 1 and holds if it is 0. The century bit is writable only while the write halt is set. Century-enable and frequency-test (day bit 6) can be written at any time.
- R9: The battery-low flag (date bit 6) is read-only. At each midnight rollover it takes the value of battery-low enable (date bit 7) AND battery_low, and between rollovers it holds.
- R10: Bits outside the defined fields read as 0 whatever was written: control 5:0, minutes 7, hours 7:6, day 7 and 3, month 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register index within the eight clock bytes |
| wr_en | input | 1 | Write strobe for the indexed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the indexed register |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| battery_low | input | 1 | Battery voltage below threshold |

## Verification
The assertions take two things for granted about the inputs:
- software loads only in-range BCD values, so the hour counter can never leave 00-23;
- a tick and a register write never fall in the same cycle, so refresh never competes with a software write to the same shadow.

The stimulus respects both limits. Random loads draw dates of 28 or less, months 1-12, hours 0-23 and minutes/seconds 0-59. The bench tasks also place ticks and writes in separate cycles. Directed loads push the counters to month ends, leap and non-leap February, the 99-to-00 year wrap with and without century-enable, and midnight with the battery input both high and low.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_W  = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);

  localparam logic [IDX_W-1:0] IX_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] IX_SEC   = 3'd1;
  localparam logic [IDX_W-1:0] IX_MIN   = 3'd2;
  localparam logic [IDX_W-1:0] IX_HOUR  = 3'd3;
  localparam logic [IDX_W-1:0] IX_DAY   = 3'd4;
  localparam logic [IDX_W-1:0] IX_DATE  = 3'd5;
  localparam logic [IDX_W-1:0] IX_MONTH = 3'd6;
  localparam logic [IDX_W-1:0] IX_YEAR  = 3'd7;

  typedef struct packed {
    logic       cb;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_len(logic [4:0] m, logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
  import rtc_pkg::*;
#(
  parameter rtc_time_t RST_T = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  input  logic      cen,
  output rtc_time_t now_t,
  output rtc_time_t next_t,
  output logic      day_roll
);

  rtc_time_t adv;
  logic      roll;

  always_comb begin
    logic [7:0] t;
    adv  = now_t;
    roll = 1'b0;
    t    = 8'h00;
    if (now_t.sec >= 7'h59) begin
      adv.sec = 7'h00;
      if (now_t.min >= 7'h59) begin
        adv.min = 7'h00;
        if (now_t.hour >= 6'h23) begin
          adv.hour = 6'h00;
          roll     = 1'b1;
          adv.dow  = (now_t.dow >= 3'd7) ? 3'd1 : now_t.dow + 3'd1;
          if (now_t.date >= month_len(now_t.month, now_t.year)) begin
            adv.date = 6'h01;
            if (now_t.month >= 5'h12) begin
              adv.month = 5'h01;
              if (now_t.year >= 8'h99) begin
                adv.year = 8'h00;
                adv.cb   = now_t.cb ^ cen;
              end else begin
                adv.year = bcd_inc(now_t.year);
              end
            end else begin
              t         = bcd_inc({3'b000, now_t.month});
              adv.month = t[4:0];
            end
          end else begin
            t        = bcd_inc({2'b00, now_t.date});
            adv.date = t[5:0];
          end
        end else begin
          t        = bcd_inc({2'b00, now_t.hour});
          adv.hour = t[5:0];
        end
      end else begin
        t       = bcd_inc({1'b0, now_t.min});
        adv.min = t[6:0];
      end
    end else begin
      t       = bcd_inc({1'b0, now_t.sec});
      adv.sec = t[6:0];
    end
  end

  always_comb begin
    if (load)      next_t = load_val;
    else if (step) next_t = adv;
    else           next_t = now_t;
  end

  assign day_roll = step & roll & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) now_t <= RST_T;
    else        now_t <= next_t;
  end

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_pkg::*;
#(
  parameter rtc_time_t RST_T = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  rtc_time_t         fresh,
  input  logic [NREG-1:0]   wr_sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              w_bit,
  output rtc_time_t         shadow
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RST_T;
    end else if (refresh) begin
      shadow <= fresh;
    end else begin
      if (wr_sel[IX_SEC])   shadow.sec   <= wdata[6:0];
      if (wr_sel[IX_MIN])   shadow.min   <= wdata[6:0];
      if (wr_sel[IX_HOUR])  shadow.hour  <= wdata[5:0];
      if (wr_sel[IX_DAY]) begin
        shadow.dow <= wdata[2:0];
        if (w_bit) shadow.cb <= wdata[4];
      end
      if (wr_sel[IX_DATE])  shadow.date  <= wdata[5:0];
      if (wr_sel[IX_MONTH]) shadow.month <= wdata[4:0];
      if (wr_sel[IX_YEAR])  shadow.year  <= wdata;
    end
  end

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_YEAR  = 8'h00,
  parameter logic [4:0] RST_MONTH = 5'h01,
  parameter logic [5:0] RST_DATE  = 6'h01,
  parameter logic [2:0] RST_DOW   = 3'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] addr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             tick_1hz,
  input  logic             battery_low
);

  localparam rtc_time_t RST_T = '{cb: 1'b0, year: RST_YEAR, month: RST_MONTH,
                                  date: RST_DATE, dow: RST_DOW, hour: 6'h00,
                                  min: 7'h00, sec: 7'h00};

  logic            w_bit, r_bit, stop_bit, ft_bit, cen_bit, ble_bit, bl_flag;
  logic [NREG-1:0] wr_sel;
  logic            load_pulse, refresh, step, day_roll;
  rtc_time_t       live_t, next_t, sh_t;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (addr == IDX_W'(i));
  end

  assign load_pulse = wr_sel[IX_CTRL] & w_bit & ~wdata[7];
  assign refresh    = tick_1hz & ~w_bit & ~r_bit;
  assign step       = tick_1hz & ~stop_bit;

  rtc_live_counter #(.RST_T(RST_T)) u_live (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load_pulse),
    .load_val(sh_t), .cen(cen_bit), .now_t(live_t), .next_t(next_t),
    .day_roll(day_roll)
  );

  rtc_shadow_bank #(.RST_T(RST_T)) u_shadow (
    .clk(clk), .rst_n(rst_n), .refresh(refresh), .fresh(next_t),
    .wr_sel(wr_sel), .wdata(wdata), .w_bit(w_bit), .shadow(sh_t)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_bit    <= 1'b0;
      r_bit    <= 1'b0;
      stop_bit <= 1'b1;
      ft_bit   <= 1'b0;
      cen_bit  <= 1'b0;
      ble_bit  <= 1'b0;
      bl_flag  <= 1'b0;
    end else begin
      if (wr_sel[IX_CTRL]) begin
        w_bit <= wdata[7];
        r_bit <= wdata[6];
      end
      if (wr_sel[IX_SEC]) stop_bit <= wdata[7];
      if (wr_sel[IX_DAY]) begin
        ft_bit  <= wdata[6];
        cen_bit <= wdata[5];
      end
      if (wr_sel[IX_DATE]) ble_bit <= wdata[7];
      if (day_roll) bl_flag <= ble_bit & battery_low;
    end
  end

  always_comb begin
    case (addr)
      IX_CTRL:  rdata = {w_bit, r_bit, 6'b000000};
      IX_SEC:   rdata = {stop_bit, sh_t.sec};
      IX_MIN:   rdata = {1'b0, sh_t.min};
      IX_HOUR:  rdata = {2'b00, sh_t.hour};
      IX_DAY:   rdata = {1'b0, ft_bit, cen_bit, sh_t.cb, 1'b0, sh_t.dow};
      IX_DATE:  rdata = {ble_bit, bl_flag, sh_t.date};
      IX_MONTH: rdata = {3'b000, sh_t.month};
      default:  rdata = sh_t.year;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick_1hz,
  input logic      wr_en,
  input logic      w_bit,
  input logic      r_bit,
  input logic      stop_bit,
  input logic      cen_bit,
  input logic      load_pulse,
  input logic      day_roll,
  input logic      bl_flag,
  input rtc_time_t live_t,
  input rtc_time_t sh_t
);

  AST_REFRESH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && !r_bit && !w_bit && !wr_en |=> sh_t == live_t); // R2

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (r_bit || w_bit) && !wr_en |=> $stable(sh_t)); // R3

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> live_t == $past(sh_t)); // R4

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit && !load_pulse |=> $stable(live_t)); // R5

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live_t.hour <= 6'h23); // R6

  AST_CB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_bit && !load_pulse |=> $stable(live_t.cb)); // R8

  AST_BL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !day_roll |=> $stable(bl_flag)); // R9

endmodule

bind rtc_calendar_regs rtc_calendar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
  .w_bit(w_bit), .r_bit(r_bit), .stop_bit(stop_bit), .cen_bit(cen_bit),
  .load_pulse(load_pulse), .day_roll(day_roll), .bl_flag(bl_flag),
  .live_t(live_t), .sh_t(sh_t)
);

// File: tb/tb_rtc_calendar_regs.sv
module tb_rtc_calendar_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick_1hz = 1'b0;
  logic       battery_low = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .tick_1hz(tick_1hz), .battery_low(battery_low)
  );

  int  checks = 0, errors = 0;
  bit  done = 0;
  // model: 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year,7 century
  int  lv[8], sh[8];
  bit  mw, mr, mstop, mft, mcen, mble, mbl;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unb(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    logic [7:0] b;
    case (a)
      0: return {mw, mr, 6'b0};
      1: begin b = bcd(sh[0]); return {mstop, b[6:0]}; end
      2: return bcd(sh[1]);
      3: return bcd(sh[2]);
      4: return {1'b0, mft, mcen, sh[7][0], 1'b0, sh[3][2:0]};
      5: begin b = bcd(sh[4]); return {mble, mbl, b[5:0]}; end
      6: return bcd(sh[5]);
      default: return bcd(sh[6]);
    endcase
  endfunction

  task automatic model_tick(bit batt);
    if (!mstop) begin
      lv[0]++;
      if (lv[0] > 59) begin
        lv[0] = 0; lv[1]++;
        if (lv[1] > 59) begin
          lv[1] = 0; lv[2]++;
          if (lv[2] > 23) begin
            lv[2] = 0;
            mbl = mble & batt;
            lv[3] = lv[3] % 7 + 1;
            lv[4]++;
            if (lv[4] > mdays(lv[5], lv[6])) begin
              lv[4] = 1; lv[5]++;
              if (lv[5] > 12) begin
                lv[5] = 1; lv[6]++;
                if (lv[6] > 99) begin
                  lv[6] = 0;
                  if (mcen) lv[7] = 1 - lv[7];
                end
              end
            end
          end
        end
      end
    end
    if (!mw && !mr) sh = lv;
  endtask

  task automatic model_write(int a, logic [7:0] d);
    case (a)
      0: begin if (mw && !d[7]) lv = sh; mw = d[7]; mr = d[6]; end
      1: begin mstop = d[7]; sh[0] = unb({1'b0, d[6:0]}); end
      2: sh[1] = unb({1'b0, d[6:0]});
      3: sh[2] = unb({2'b0, d[5:0]});
      4: begin mft = d[6]; mcen = d[5]; if (mw) sh[7] = int'(d[4]); sh[3] = int'(d[2:0]); end
      5: begin mble = d[7]; sh[4] = unb({2'b0, d[5:0]}); end
      6: sh[5] = unb({3'b0, d[4:0]});
      default: sh[6] = unb(d);
    endcase
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic tick(bit batt);
    @(negedge clk);
    tick_1hz = 1'b1; battery_low = batt;
    @(negedge clk);
    tick_1hz = 1'b0;
    model_tick(batt);
  endtask

  task automatic chk(string tag, int a);
    @(negedge clk);
    addr = 3'(a);
    #1;
    checks++;
    if (rdata !== exp_byte(a)) begin
      errors++;
      $display("FAIL %s reg%0d got %02h expected %02h", tag, a, rdata, exp_byte(a));
    end
  endtask

  task automatic chk_all(string tag);
    for (int a = 0; a < 8; a++) chk(tag, a);
  endtask

  task automatic set_time(int s, int mi, int h, logic [7:0] day, logic [7:0] dt, int mo, int y);
    wr(0, 8'h80);
    wr(1, bcd(s)); wr(2, bcd(mi)); wr(3, bcd(h)); wr(4, day);
    wr(5, dt); wr(6, bcd(mo)); wr(7, bcd(y));
    wr(0, 8'h00);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    lv = '{0, 0, 0, 1, 1, 1, 0, 0};
    sh = lv;
    mw = 0; mr = 0; mstop = 1; mft = 0; mcen = 0; mble = 0; mbl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_all("R1");
    tick(0); chk("R5", 1);
    wr(1, 8'h00);
    repeat (3) tick(0);
    chk_all("R2");

    wr(0, 8'hFF); chk("R10", 0);
    wr(6, 8'hF2); wr(3, 8'hE3); wr(5, 8'h45); wr(2, 8'hB7); wr(4, 8'h8B);
    chk_all("R10");
    chk("R9", 5);
    wr(0, 8'h00); tick(0);
    chk_all("R4");

    wr(0, 8'h40); tick(0); tick(0);
    chk_all("R3");
    wr(0, 8'h00); tick(0);
    chk_all("R3");

    set_time(59, 59, 23, 8'h27, 8'h31, 12, 99); tick(0);
    chk_all("R8");
    chk("R6", 4);
    wr(4, 8'h20); chk("R8", 4);
    set_time(59, 59, 23, 8'h07, 8'h31, 12, 99); tick(0);
    chk_all("R8");

    set_time(59, 59, 23, 8'h01, 8'h28, 2, 24); tick(0); chk_all("R7");
    set_time(59, 59, 23, 8'h01, 8'h28, 2, 23); tick(0); chk_all("R7");
    set_time(59, 59, 23, 8'h01, 8'h30, 4, 23); tick(0); chk_all("R7");
    set_time(59, 59, 23, 8'h01, 8'h31, 1, 23); tick(0); chk_all("R7");

    set_time(59, 59, 23, 8'h03, 8'h90, 5, 10); tick(1); chk("R9", 5);
    tick(0); chk("R9", 5);
    set_time(59, 59, 23, 8'h03, 8'h90, 5, 10); tick(0); chk("R9", 5);
    set_time(58, 59, 23, 8'h03, 8'h90, 5, 10); tick(1); chk("R9", 5);
    tick(1); chk("R9", 5);
    set_time(59, 59, 9, 8'h03, 8'h10, 5, 10); tick(0); chk_all("R6");

    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        tick(1'($urandom_range(0, 1)));
      end else begin
        int a;
        logic [7:0] d;
        a = $urandom_range(0, 7);
        case (a)
          0: d = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'b0};
          1: d = {($urandom_range(0, 15) == 0), 7'(bcd($urandom_range(0, 59)))};
          2: d = bcd($urandom_range(0, 59));
          3: d = bcd($urandom_range(0, 23));
          4: d = {1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'b0, 3'($urandom_range(1, 7))};
          5: d = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  6'(bcd($urandom_range(1, 28)))};
          6: d = bcd($urandom_range(1, 12));
          default: d = bcd($urandom_range(0, 99));
        endcase
        wr(a, d);
      end
      chk_all("R2");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule